// File: doc/BRIEF.md
# E1 Signaling-Slot Multiframe Extractor

This block sits behind an E1 frame aligner. Each cycle it may receive one serial bit, along with the timeslot number and bit position of that bit and a flag that says frame alignment is held. It watches timeslot 16, where a 16-frame multiframe carries channel-associated signaling. It finds the multiframe boundary from the all-zero nibble that opens timeslot 16 in frame 0, and it keeps a running frame index. It then delivers the 4-bit signaling code of each of the 30 voice channels through a single registered write port.

In frames 1 to 15, timeslot 16 holds two nibbles. In frame n, the first nibble belongs to the voice channel in timeslot n and the second nibble to the channel in timeslot n+16. A downstream table or state machine uses the write port, indexed by timeslot number, to hold the current signaling state. The block also gives a multiframe-lock flag and a one-cycle loss pulse. The loss pulse lets downstream logic freeze or clear its signaling state.

Top module: `e1mf_sig_extract`

## Requirements
- R1: While `rst` is high and on the first cycle after, `mf_lock`, `mf_loss` and `sig_we` are 0 and `frm_idx` is 0.
- R2: A bit is taken only in a cycle with `bit_vld`=1 and `frm_aligned`=1. Timeslot-16 bits arrive with `bit_pos` 0 first. Positions 0..3 form the first nibble (position 0 is the nibble's MSB), and positions 4..7 form the second. Cycles with `bit_vld`=0 have no effect, whatever the other inputs carry.
- R3: While searching, a first nibble of 0000 in timeslot 16 marks that frame as frame 0 (`frm_idx`=0). Lock is declared after the last timeslot-16 bit of the following frame, if that whole byte is non-zero. At that moment `frm_idx` is 1.
- R4: `frm_idx` advances by one at every taken bit with timeslot 0 and position 0, and wraps from 15 to 0.
- R5: While locked, in frame n (1..15), the first nibble is written with `sig_ch`=n and the second nibble with `sig_ch`=n+16. `sig_val` is the nibble. `sig_we` is high for one cycle, in the cycle after the bit that completes the nibble.
- R6: No write is issued in frame 0 or while unlocked, and that includes the confirmation frame. After acquisition, the first multiframe therefore gives 28 writes, and every later locked multiframe gives 30.
- R7: A single frame 0 whose first timeslot-16 nibble is not 0000 keeps lock. A following correct frame 0 clears the miss count.
- R8: Two consecutive frame-0 misses drop `mf_lock` and give a one-cycle `mf_loss` pulse. No further writes follow until a new lock.
- R9: When `frm_alignment` falls (`frm_aligned`=0), lock drops at the next edge and `mf_loss` pulses once if lock was held. No write is made while alignment is low, and reacquisition follows R3.
- R10: If the byte that follows a 0000 candidate nibble is all zero, no lock is declared and the search resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_aligned | input | 1 | Frame alignment held by the upstream aligner |
| bit_vld | input | 1 | A data bit is present this cycle |
| bit_in | input | 1 | Serial data bit |
| ts_num | input | 5 | Timeslot number of the bit, 0..31 |
| bit_pos | input | 3 | Position of the bit in its timeslot, 0 sent first |
| mf_lock | output | 1 | Multiframe lock held |
| mf_loss | output | 1 | One-cycle pulse when multiframe lock is lost |
| frm_idx | output | 4 | Frame number within the multiframe |
| sig_we | output | 1 | Signaling write strobe |
| sig_ch | output | 5 | Timeslot number of the voice channel written |
| sig_val | output | 4 | Signaling nibble |

## Verification
The bench sends whole multiframes in which every channel's signaling code comes from a formula of the channel number and a pass number. The same channel therefore carries a different code in each pass, and a swapped nibble, a wrong channel offset or a stale value shows up as a mismatch. The streams include:
- A dense bit stream and a stream with an idle cycle that carries junk before every bit. Together these show that only valid bits are consumed.
- Frame-0 patterns with one miss, two misses, and a miss followed by recovery. These separate tolerance of a single miss from loss of lock.
- A candidate followed by an all-zero byte, which must not lock.
- A drop of alignment in mid-multiframe, with junk timeslot-16 bits during the drop.

Write counts of 28 or 30 per multiframe tell first-lock behaviour apart from steady state.

// File: rtl/e1mf_pkg.sv
package e1mf_pkg;
  typedef enum logic [1:0] {
    MF_SEARCH  = 2'd0,
    MF_CONFIRM = 2'd1,
    MF_LOCKED  = 2'd2
  } mf_state_t;
endpackage

// File: rtl/e1mf_ts16_shift.sv
// Assembles the two signaling nibbles of the signaling timeslot.
module e1mf_ts16_shift #(
  parameter int TS_W   = 5,
  parameter int SIG_TS = 16,
  parameter int NIB_W  = 4,
  parameter int POS_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic [TS_W-1:0]      ts,
  input  logic [POS_W-1:0]     pos,
  input  logic                 bit_in,
  output logic                 hi_done,
  output logic                 lo_done,
  output logic [NIB_W-1:0]     nib,
  output logic [2*NIB_W-1:0]   byte_val
);
  localparam int SH_W = 2*NIB_W - 1;

  logic [SH_W-1:0] sh;
  logic            in_sig;

  assign in_sig   = take && (ts == TS_W'(SIG_TS));
  assign hi_done  = in_sig && (pos == POS_W'(NIB_W-1));
  assign lo_done  = in_sig && (pos == POS_W'(2*NIB_W-1));
  assign nib      = {sh[NIB_W-2:0], bit_in};
  assign byte_val = {sh, bit_in};

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else if (in_sig) sh <= {sh[SH_W-2:0], bit_in};
  end
endmodule

// File: rtl/e1mf_mf_fsm.sv
// Multiframe search, confirmation, lock supervision and frame counting.
module e1mf_mf_fsm
  import e1mf_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int MF_FRAMES  = 16,
  parameter int MISS_LIMIT = 2,
  localparam int IDX_W     = $clog2(MF_FRAMES),
  localparam int MISS_W    = $clog2(MISS_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               aligned,
  input  logic               frm_start,
  input  logic               hi_done,
  input  logic               lo_done,
  input  logic [NIB_W-1:0]   nib,
  input  logic [2*NIB_W-1:0] byte_val,
  output logic               lock,
  output logic               loss,
  output logic [IDX_W-1:0]   idx
);
  mf_state_t         state;
  logic [MISS_W-1:0] miss;

  assign lock = (state == MF_LOCKED);

  always_ff @(posedge clk) begin
    if (rst || !aligned) begin
      state <= MF_SEARCH;
      idx   <= '0;
      miss  <= '0;
      loss  <= !rst && (state == MF_LOCKED);
    end else begin
      loss <= 1'b0;
      if (frm_start) idx <= idx + IDX_W'(1);
      case (state)
        MF_SEARCH: begin
          if (hi_done && nib == '0) begin
            state <= MF_CONFIRM;
            idx   <= '0;
          end
        end
        MF_CONFIRM: begin
          if (lo_done && idx == IDX_W'(1)) begin
            state <= (byte_val != '0) ? MF_LOCKED : MF_SEARCH;
            miss  <= '0;
          end
        end
        MF_LOCKED: begin
          if (hi_done && idx == '0) begin
            if (nib == '0) begin
              miss <= '0;
            end else if (miss == MISS_W'(MISS_LIMIT - 1)) begin
              state <= MF_SEARCH;
              loss  <= 1'b1;
              miss  <= '0;
            end else begin
              miss <= miss + MISS_W'(1);
            end
          end
        end
        default: state <= MF_SEARCH;
      endcase
    end
  end
endmodule

// File: rtl/e1mf_sig_writer.sv
// Registered per-channel signaling write port.
module e1mf_sig_writer #(
  parameter int TS_W   = 5,
  parameter int SIG_TS = 16,
  parameter int NIB_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aligned,
  input  logic             lock,
  input  logic [IDX_W-1:0] idx,
  input  logic             hi_done,
  input  logic             lo_done,
  input  logic [NIB_W-1:0] nib,
  output logic             we,
  output logic [TS_W-1:0]  ch,
  output logic [NIB_W-1:0] val
);
  logic [TS_W-1:0] base_ch;
  assign base_ch = TS_W'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      we  <= 1'b0;
      ch  <= '0;
      val <= '0;
    end else begin
      we <= aligned && lock && (idx != '0) && (hi_done || lo_done);
      if (hi_done || lo_done) begin
        ch  <= hi_done ? base_ch : base_ch + TS_W'(SIG_TS);
        val <= nib;
      end
    end
  end
endmodule

// File: rtl/e1mf_sig_extract.sv
module e1mf_sig_extract #(
  parameter int TS_W       = 5,
  parameter int NIB_W      = 4,
  parameter int MF_FRAMES  = 16,
  parameter int MISS_LIMIT = 2,
  localparam int SIG_TS    = (1 << TS_W) / 2,
  localparam int POS_W     = $clog2(2*NIB_W),
  localparam int IDX_W     = $clog2(MF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_aligned,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic [TS_W-1:0]  ts_num,
  input  logic [POS_W-1:0] bit_pos,
  output logic             mf_lock,
  output logic             mf_loss,
  output logic [IDX_W-1:0] frm_idx,
  output logic             sig_we,
  output logic [TS_W-1:0]  sig_ch,
  output logic [NIB_W-1:0] sig_val
);
  logic               take, frm_start, hi_done, lo_done;
  logic [NIB_W-1:0]   nib;
  logic [2*NIB_W-1:0] byte_val;

  assign take      = bit_vld && frm_aligned;
  assign frm_start = take && ts_num == '0 && bit_pos == '0;

  e1mf_ts16_shift #(.TS_W(TS_W), .SIG_TS(SIG_TS), .NIB_W(NIB_W), .POS_W(POS_W)) i_shift (
    .clk(clk), .rst(rst), .take(take), .ts(ts_num), .pos(bit_pos), .bit_in(bit_in),
    .hi_done(hi_done), .lo_done(lo_done), .nib(nib), .byte_val(byte_val)
  );

  e1mf_mf_fsm #(.NIB_W(NIB_W), .MF_FRAMES(MF_FRAMES), .MISS_LIMIT(MISS_LIMIT)) i_fsm (
    .clk(clk), .rst(rst), .aligned(frm_aligned), .frm_start(frm_start),
    .hi_done(hi_done), .lo_done(lo_done), .nib(nib), .byte_val(byte_val),
    .lock(mf_lock), .loss(mf_loss), .idx(frm_idx)
  );

  e1mf_sig_writer #(.TS_W(TS_W), .SIG_TS(SIG_TS), .NIB_W(NIB_W), .IDX_W(IDX_W)) i_wr (
    .clk(clk), .rst(rst), .aligned(frm_aligned), .lock(mf_lock), .idx(frm_idx),
    .hi_done(hi_done), .lo_done(lo_done), .nib(nib),
    .we(sig_we), .ch(sig_ch), .val(sig_val)
  );
endmodule

// File: rtl/e1mf_sig_extract_chk.sv
module e1mf_sig_extract_chk #(
  parameter int TS_W  = 5,
  parameter int POS_W = 3,
  parameter int IDX_W = 4,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_aligned,
  input logic             bit_vld,
  input logic             bit_in,
  input logic [TS_W-1:0]  ts_num,
  input logic [POS_W-1:0] bit_pos,
  input logic             mf_lock,
  input logic             mf_loss,
  input logic [IDX_W-1:0] frm_idx,
  input logic             sig_we,
  input logic [TS_W-1:0]  sig_ch,
  input logic [NIB_W-1:0] sig_val
);
  localparam int SIG_TS = (1 << TS_W) / 2;
  logic fs;
  assign fs = bit_vld && frm_aligned && ts_num == '0 && bit_pos == '0;

  AST_WE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    sig_we |-> $past(mf_lock)); // R6
  AST_CH_VALID: assert property (@(posedge clk) disable iff (rst)
    sig_we |-> (sig_ch != '0 && sig_ch != TS_W'(SIG_TS))); // R5
  AST_LOSS_PULSE: assert property (@(posedge clk) disable iff (rst)
    mf_loss |=> !mf_loss); // R8
  AST_LOSS_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    mf_loss |-> !mf_lock); // R8
  AST_UNALIGNED_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !frm_aligned |=> (!mf_lock && !sig_we)); // R9
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (fs && mf_lock) |=> frm_idx == $past(frm_idx) + IDX_W'(1)); // R4
  AST_LOCK_AT_FRAME1: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_lock) |-> frm_idx == IDX_W'(1)); // R3
endmodule

bind e1mf_sig_extract e1mf_sig_extract_chk #(
  .TS_W(TS_W), .POS_W(POS_W), .IDX_W(IDX_W), .NIB_W(NIB_W)
) i_chk (.*);

// File: tb/test_e1mf_sig_extract.sv
`timescale 1ns/1ps
module test_e1mf_sig_extract;
  logic clk = 1'b0;
  logic rst, frm_aligned, bit_vld, bit_in;
  logic [4:0] ts_num;
  logic [2:0] bit_pos;
  logic mf_lock, mf_loss, sig_we;
  logic [3:0] frm_idx, sig_val;
  logic [4:0] sig_ch;

  int n_chk = 0, n_err = 0, wr_cnt = 0, loss_cnt = 0, cur_pass = 0;

  always #2.5 clk = ~clk;

  e1mf_sig_extract i_e1mf_sig_extract (
    .clk(clk), .rst(rst), .frm_aligned(frm_aligned), .bit_vld(bit_vld), .bit_in(bit_in),
    .ts_num(ts_num), .bit_pos(bit_pos), .mf_lock(mf_lock), .mf_loss(mf_loss),
    .frm_idx(frm_idx), .sig_we(sig_we), .sig_ch(sig_ch), .sig_val(sig_val)
  );

  function automatic logic [3:0] expv(input int ch, input int pass);
    return 4'(((ch*5 + pass*3) % 15) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write and loss monitor (R5): every write must name a voice channel with its code.
  always @(negedge clk) begin
    if (!rst && sig_we) begin
      wr_cnt++;
      check(sig_ch != 0 && sig_ch != 16, "R5 channel", sig_ch, 1);
      check(sig_val == expv(sig_ch, cur_pass), "R5 value", sig_val, expv(sig_ch, cur_pass));
    end
    if (!rst && mf_loss) loss_cnt++;
  end

  task automatic send_bit(input logic b, input int t, input int p, input bit gap);
    if (gap) begin
      bit_vld = 1'b0; bit_in = ~b; ts_num = 5'd16; bit_pos = 3'(p);
      @(posedge clk); #1;
    end
    bit_vld = 1'b1; bit_in = b; ts_num = 5'(t); bit_pos = 3'(p);
    @(posedge clk); #1;
    bit_vld = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b16, input int f, input bit chk_idx, input bit gap);
    for (int t = 0; t < 32; t++)
      for (int p = 0; p < 8; p++) begin
        send_bit((t == 16) ? b16[7-p] : logic'(((t*13 + p*7 + f) % 3) == 0), t, p, gap);
        if (chk_idx && t == 5 && p == 0) check(frm_idx == 4'(f), "R4 frame index", frm_idx, f);
      end
  endtask

  task automatic send_mf_part(input int pass, input logic [3:0] f0hi, input bit gap,
                              input bit chk_idx, input int first, input int last);
    cur_pass = pass;
    for (int f = first; f <= last; f++)
      send_frame((f == 0) ? {f0hi, 4'hB} : {expv(f, pass), expv(f + 16, pass)}, f, chk_idx, gap);
  endtask

  task automatic send_mf(input int pass, input logic [3:0] f0hi, input bit gap, input bit chk_idx);
    wr_cnt = 0;
    send_mf_part(pass, f0hi, gap, chk_idx, 0, 15);
  endtask

  initial begin
    #(150000 * 5);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; frm_aligned = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; ts_num = '0; bit_pos = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    check(!mf_lock, "R1 lock", mf_lock, 0);
    check(!mf_loss, "R1 loss", mf_loss, 0);
    check(!sig_we, "R1 write", sig_we, 0);
    check(frm_idx == 0, "R1 index", frm_idx, 0);

    frm_aligned = 1'b1;
    send_frame(8'h5A, 3, 1'b0, 1'b0);
    send_frame(8'h5A, 4, 1'b0, 1'b0);
    check(!mf_lock, "R3 no lock without 0000", mf_lock, 0);

    // R3/R6: acquisition, 28 writes in the first multiframe
    wr_cnt = 0;
    send_mf_part(1, 4'h0, 1'b0, 1'b0, 0, 0);
    check(!mf_lock, "R3 no lock in candidate frame", mf_lock, 0);
    send_mf_part(1, 4'h0, 1'b0, 1'b0, 1, 15);
    check(mf_lock, "R3 lock", mf_lock, 1);
    check(wr_cnt == 28, "R6 first multiframe writes", wr_cnt, 28);

    send_mf(2, 4'h0, 1'b0, 1'b1);
    check(wr_cnt == 30, "R5 steady writes", wr_cnt, 30);

    // R2: idle cycles with junk between bits
    send_mf(3, 4'h0, 1'b1, 1'b1);
    check(wr_cnt == 30, "R2 gapped stream writes", wr_cnt, 30);

    // R7: single miss tolerated, then cleared
    send_mf(4, 4'h3, 1'b0, 1'b0);
    check(mf_lock && wr_cnt == 30, "R7 single miss keeps lock", wr_cnt, 30);
    send_mf(5, 4'h0, 1'b0, 1'b0);
    send_mf(6, 4'h3, 1'b0, 1'b0);
    check(mf_lock && loss_cnt == 0, "R7 miss count cleared", loss_cnt, 0);

    // R8: second consecutive miss
    send_mf(7, 4'h5, 1'b0, 1'b0);
    check(!mf_lock, "R8 lock dropped", mf_lock, 0);
    check(loss_cnt == 1, "R8 loss pulse", loss_cnt, 1);
    check(wr_cnt == 0, "R8 no writes after loss", wr_cnt, 0);

    send_mf(8, 4'h0, 1'b0, 1'b0);
    check(mf_lock && wr_cnt == 28, "R3 relock", wr_cnt, 28);

    // R9: alignment loss mid multiframe
    send_mf(9, 4'h0, 1'b0, 1'b0);
    wr_cnt = 0;
    send_mf_part(10, 4'h0, 1'b0, 1'b0, 0, 4);
    check(wr_cnt == 8, "R5 partial writes", wr_cnt, 8);
    frm_aligned = 1'b0;
    wr_cnt = 0;
    for (int p = 0; p < 8; p++) send_bit(1'b0, 16, p, 1'b0);
    for (int p = 0; p < 8; p++) send_bit(1'b1, 16, p, 1'b0);
    check(!mf_lock, "R9 lock dropped", mf_lock, 0);
    check(loss_cnt == 2, "R9 loss pulse", loss_cnt, 2);
    check(wr_cnt == 0, "R9 no writes unaligned", wr_cnt, 0);
    frm_aligned = 1'b1;
    send_mf_part(10, 4'h0, 1'b0, 1'b0, 5, 15);
    check(!mf_lock && wr_cnt == 0, "R9 stays unlocked", wr_cnt, 0);
    send_mf(11, 4'h0, 1'b0, 1'b0);
    check(mf_lock && wr_cnt == 28, "R9 reacquire", wr_cnt, 28);

    // R10: zero byte after candidate
    frm_aligned = 1'b0;
    @(posedge clk); #1;
    frm_aligned = 1'b1;
    send_frame(8'h0B, 0, 1'b0, 1'b0);
    send_frame(8'h00, 1, 1'b0, 1'b0);
    send_frame(8'h77, 2, 1'b0, 1'b0);
    send_frame(8'h77, 3, 1'b0, 1'b0);
    check(!mf_lock, "R10 zero byte rejects lock", mf_lock, 0);
    send_mf(12, 4'h0, 1'b0, 1'b0);
    check(mf_lock && wr_cnt == 28, "R10 later lock", wr_cnt, 28);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule